// File: doc/BRIEF.md
# PLL Feedback Recalibration Sequencer

This block walks a bonded transmit PLL through recalibration after power-up calibration. Such a PLL normally takes its feedback from the master clock generation block. Before the PLL can be recalibrated, that feedback has to be replaced by the PLL's own internal feedback, and it has to be put back once the PLL is locked again. The block then recalibrates the transmitter analog front end (TX PMA) of every channel the PLL feeds. Each step is carried out through a memory-mapped reconfiguration port that has a wait-request handshake.

A start pulse selects the PLL flavour on `pllSel`: 0 selects the LC-tank PLL and 1 selects the fractional PLL. The sequencer then proceeds in this order:

1. It sets the feedback-select bit with a read-modify-write.
2. It requests a PLL calibration and waits for it to finish.
3. It waits for lock.
4. It clears the feedback-select bit with a second read-modify-write.
5. It requests one TX PMA calibration per bonded channel, one at a time.

The block ends with a one-cycle `done` pulse. If the lock wait or any calibration wait takes too long, the block stops and holds `error` instead.

Top module: `pll_fb_recal`

## Requirements
- R1: `pllSel` is sampled when a start is accepted. The value 0 selects the LC-tank feedback control at offset 0x110, bit 2. The value 1 selects the fractional feedback control at offset 0x126, bit 0. The other register is never accessed.
- R2: The first bus accesses are a read of the selected register, then a write to the same offset. The write data is the captured read data with the feedback bit forced to 1. Read data is captured on the cycle the read is accepted.
- R3: Once the set-write is accepted, a write of value 1 to `PLL_CAL_ADDR` (default 0x100) requests the PLL calibration. The calibration counts as finished when `pllCalBusy` has been seen high and then is seen low.
- R4: After the PLL calibration finishes, the block does nothing further until `pllLocked` is high. It then reads the selected register again and writes back the read data with the feedback bit cleared to 0.
- R5: After the restore write, the block writes value 1 to `CH_CAL_BASE + k` (default base 0x200) for k = 0 up to NCH-1, in ascending order. Each request waits for `pmaCalBusy[k]` to be seen high and then low before the next request is issued.
- R6: While a read or write is pending and `avWait` is high, address, write data, read and write stay unchanged on the next cycle. Read and write are never high together.
- R7: If lock is not reached within LOCK_TIMEOUT cycles, `error` goes high and `done` stays low. The error then holds, with no further bus activity, until the next start.
- R8: If a PLL calibration or channel calibration does not complete within CAL_TIMEOUT cycles, `error` goes high and `done` stays low. This includes the case where busy never rises. No later step is issued.
- R9: `done` is high for exactly one cycle after the last channel calibration completes, and is never high together with `error`.
- R10: A start that arrives while a sequence is running is ignored, including the `pllSel` value presented with it. A start while idle or in error begins a new sequence.
- R11: After reset, read, write, `done` and `error` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a recalibration sequence |
| pllSel | input | 1 | 0 = LC-tank PLL, 1 = fractional PLL |
| pllLocked | input | 1 | PLL lock indication |
| pllCalBusy | input | 1 | PLL calibration in progress |
| pmaCalBusy | input | NCH | Per-channel TX PMA calibration in progress |
| avRead | output | 1 | Bus read request |
| avWrite | output | 1 | Bus write request |
| avAddr | output | AW | Bus address |
| avWdata | output | DW | Bus write data |
| avRdata | input | DW | Bus read data |
| avWait | input | 1 | Bus stall; the request is held while high |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Timeout error, held until the next start |

## Verification
The bench builds the block with NCH = 3, CAL_TIMEOUT = 40 and LOCK_TIMEOUT = 30. With these values, every channel step and every timeout path finishes in a few dozen cycles.

The bench sweeps both PLL flavours, three stall lengths and three register contents, including all-zero and all-one registers. This shows that the read-modify-write keeps every other bit and only toggles the feedback bit.

The small timeouts also make it cheap to cover each failure point: lock never arriving, PLL calibration never starting, and the middle channel never calibrating. Recovery from the error state is exercised as well.

// File: rtl/pllrecal_pkg.sv
package pllrecal_pkg;
  localparam int CH_IDX_W = 3;

  typedef enum logic [2:0] {
    OP_RD_FB,
    OP_WR_FB_SET,
    OP_WR_FB_CLR,
    OP_WR_PLL_CAL,
    OP_WR_CH_CAL
  } busOp_e;

  typedef struct packed {
    logic                launch;
    busOp_e              op;
    logic                timerClr;
    logic                useFrac;
    logic [CH_IDX_W-1:0] chIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/pllrecal_dp.sv
module pllrecal_dp
  import pllrecal_pkg::*;
#(
  parameter int AW           = 10,
  parameter int DW           = 32,
  parameter int LC_FB_ADDR   = 'h110,
  parameter int LC_FB_BIT    = 2,
  parameter int FR_FB_ADDR   = 'h126,
  parameter int FR_FB_BIT    = 0,
  parameter int PLL_CAL_ADDR = 'h100,
  parameter int CH_CAL_BASE  = 'h200,
  parameter int TW           = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    ctl,
  input  logic          avWait,
  input  logic [DW-1:0] avRdata,
  output logic          avRead,
  output logic          avWrite,
  output logic [AW-1:0] avAddr,
  output logic [DW-1:0] avWdata,
  output logic          busAck,
  output logic [TW-1:0] timerVal
);
  logic [DW-1:0] rdCap;
  logic [DW-1:0] fbMask;
  logic [AW-1:0] fbAddr;

  always_comb begin
    fbAddr = ctl.useFrac ? AW'(FR_FB_ADDR) : AW'(LC_FB_ADDR);
    fbMask = ctl.useFrac ? (DW'(1) << FR_FB_BIT) : (DW'(1) << LC_FB_BIT);
  end

  assign busAck = (avRead | avWrite) & ~avWait;

  // bus request registers: raised on launch, dropped on acceptance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      avRead  <= 1'b0;
      avWrite <= 1'b0;
      avAddr  <= '0;
      avWdata <= '0;
      rdCap   <= '0;
    end else begin
      if (avRead && !avWait) rdCap <= avRdata;
      if (busAck) begin
        avRead  <= 1'b0;
        avWrite <= 1'b0;
      end
      if (ctl.launch) begin
        unique case (ctl.op)
          OP_RD_FB: begin
            avRead <= 1'b1;
            avAddr <= fbAddr;
          end
          OP_WR_FB_SET: begin
            avWrite <= 1'b1;
            avAddr  <= fbAddr;
            avWdata <= rdCap | fbMask;
          end
          OP_WR_FB_CLR: begin
            avWrite <= 1'b1;
            avAddr  <= fbAddr;
            avWdata <= rdCap & ~fbMask;
          end
          OP_WR_PLL_CAL: begin
            avWrite <= 1'b1;
            avAddr  <= AW'(PLL_CAL_ADDR);
            avWdata <= DW'(1);
          end
          default: begin
            avWrite <= 1'b1;
            avAddr  <= AW'(CH_CAL_BASE) + AW'(ctl.chIdx);
            avWdata <= DW'(1);
          end
        endcase
      end
    end
  end

  // saturating wait timer shared by lock and calibration waits
  always_ff @(posedge clk) begin
    if (!rstN || ctl.timerClr) timerVal <= '0;
    else if (timerVal != '1) timerVal <= timerVal + 1'b1;
  end

  a_r6_hold_req: assert property (@(posedge clk) disable iff (!rstN)
    ((avRead || avWrite) && avWait) |=>
      ($stable(avAddr) && $stable(avWdata) && $stable(avRead) && $stable(avWrite)));

  a_r6_no_rw_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(avRead && avWrite));
endmodule

// File: rtl/pllrecal_ctl.sv
module pllrecal_ctl
  import pllrecal_pkg::*;
#(
  parameter int NCH          = 6,
  parameter int CAL_TIMEOUT  = 4096,
  parameter int LOCK_TIMEOUT = 8192,
  parameter int TW           = 14
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           pllSel,
  input  logic           pllLocked,
  input  logic           pllCalBusy,
  input  logic [NCH-1:0] pmaCalBusy,
  input  logic           busAck,
  input  logic [TW-1:0]  timerVal,
  output ctlStrobe_t     ctl,
  output logic           done,
  output logic           error
);
  typedef enum logic [3:0] {
    S_IDLE, S_FB_RD1, S_FB_SET, S_PCAL_REQ, S_PCAL_WAIT, S_LOCK,
    S_FB_RD2, S_FB_CLR, S_CH_REQ, S_CH_WAIT, S_DONE, S_ERR
  } state_e;

  localparam logic [CH_IDX_W-1:0] LAST_CH = CH_IDX_W'(NCH - 1);

  state_e              state, stateNext;
  logic                fresh;
  logic                selQ;
  logic [CH_IDX_W-1:0] chIdx;
  logic                seenBusy;
  logic                chBusySel;
  logic                busyNow;
  logic                calDone;
  logic                calExpire;
  logic                lockExpire;
  logic                startOk;

  always_comb begin
    chBusySel = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (chIdx == CH_IDX_W'(i)) chBusySel = pmaCalBusy[i];
  end

  assign busyNow    = (state == S_PCAL_WAIT) ? pllCalBusy : chBusySel;
  assign calDone    = !fresh && seenBusy && !busyNow;
  assign calExpire  = !fresh && (timerVal >= TW'(CAL_TIMEOUT));
  assign lockExpire = !fresh && (timerVal >= TW'(LOCK_TIMEOUT));
  assign startOk    = start && (state == S_IDLE || state == S_ERR);

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE, S_ERR: if (start) stateNext = S_FB_RD1;
      S_FB_RD1:      if (busAck) stateNext = S_FB_SET;
      S_FB_SET:      if (busAck) stateNext = S_PCAL_REQ;
      S_PCAL_REQ:    if (busAck) stateNext = S_PCAL_WAIT;
      S_PCAL_WAIT:   if (calDone) stateNext = S_LOCK;
                     else if (calExpire) stateNext = S_ERR;
      S_LOCK:        if (pllLocked) stateNext = S_FB_RD2;
                     else if (lockExpire) stateNext = S_ERR;
      S_FB_RD2:      if (busAck) stateNext = S_FB_CLR;
      S_FB_CLR:      if (busAck) stateNext = S_CH_REQ;
      S_CH_REQ:      if (busAck) stateNext = S_CH_WAIT;
      S_CH_WAIT:     if (calDone) stateNext = (chIdx == LAST_CH) ? S_DONE : S_CH_REQ;
                     else if (calExpire) stateNext = S_ERR;
      S_DONE:        stateNext = S_IDLE;
      default:       stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      fresh    <= 1'b0;
      selQ     <= 1'b0;
      chIdx    <= '0;
      seenBusy <= 1'b0;
    end else begin
      state <= stateNext;
      fresh <= (stateNext != state);
      if (startOk) begin
        selQ  <= pllSel;
        chIdx <= '0;
      end else if (state == S_CH_WAIT && calDone && chIdx != LAST_CH) begin
        chIdx <= chIdx + 1'b1;
      end
      if (fresh) seenBusy <= busyNow;
      else if (busyNow) seenBusy <= 1'b1;
    end
  end

  always_comb begin
    ctl.timerClr = fresh;
    ctl.useFrac  = selQ;
    ctl.chIdx    = chIdx;
    ctl.launch   = 1'b0;
    ctl.op       = OP_RD_FB;
    unique case (state)
      S_FB_RD1, S_FB_RD2: begin ctl.launch = fresh; ctl.op = OP_RD_FB;      end
      S_FB_SET:           begin ctl.launch = fresh; ctl.op = OP_WR_FB_SET;  end
      S_FB_CLR:           begin ctl.launch = fresh; ctl.op = OP_WR_FB_CLR;  end
      S_PCAL_REQ:         begin ctl.launch = fresh; ctl.op = OP_WR_PLL_CAL; end
      S_CH_REQ:           begin ctl.launch = fresh; ctl.op = OP_WR_CH_CAL;  end
      default: ;
    endcase
  end

  assign done  = (state == S_DONE);
  assign error = (state == S_ERR);

  a_r4_lock_gate: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FB_RD2 && $past(state) == S_LOCK) |-> $past(pllLocked));

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_done_err_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));
endmodule

// File: rtl/pll_fb_recal.sv
module pll_fb_recal
  import pllrecal_pkg::*;
#(
  parameter int NCH          = 6,
  parameter int AW           = 10,
  parameter int DW           = 32,
  parameter int LC_FB_ADDR   = 'h110,
  parameter int LC_FB_BIT    = 2,
  parameter int FR_FB_ADDR   = 'h126,
  parameter int FR_FB_BIT    = 0,
  parameter int PLL_CAL_ADDR = 'h100,
  parameter int CH_CAL_BASE  = 'h200,
  parameter int CAL_TIMEOUT  = 4096,
  parameter int LOCK_TIMEOUT = 8192
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           pllSel,
  input  logic           pllLocked,
  input  logic           pllCalBusy,
  input  logic [NCH-1:0] pmaCalBusy,
  output logic           avRead,
  output logic           avWrite,
  output logic [AW-1:0]  avAddr,
  output logic [DW-1:0]  avWdata,
  input  logic [DW-1:0]  avRdata,
  input  logic           avWait,
  output logic           done,
  output logic           error
);
  localparam int MAX_TO = (CAL_TIMEOUT > LOCK_TIMEOUT) ? CAL_TIMEOUT : LOCK_TIMEOUT;
  localparam int TW     = $clog2(MAX_TO + 2);

  ctlStrobe_t    ctl;
  logic          busAck;
  logic [TW-1:0] timerVal;

  initial assert (NCH >= 1 && NCH <= 6) else $error("NCH must be 1..6");

  pllrecal_ctl #(
    .NCH(NCH), .CAL_TIMEOUT(CAL_TIMEOUT), .LOCK_TIMEOUT(LOCK_TIMEOUT), .TW(TW)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .pllSel(pllSel),
    .pllLocked(pllLocked), .pllCalBusy(pllCalBusy), .pmaCalBusy(pmaCalBusy),
    .busAck(busAck), .timerVal(timerVal), .ctl(ctl), .done(done), .error(error)
  );

  pllrecal_dp #(
    .AW(AW), .DW(DW), .LC_FB_ADDR(LC_FB_ADDR), .LC_FB_BIT(LC_FB_BIT),
    .FR_FB_ADDR(FR_FB_ADDR), .FR_FB_BIT(FR_FB_BIT),
    .PLL_CAL_ADDR(PLL_CAL_ADDR), .CH_CAL_BASE(CH_CAL_BASE), .TW(TW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .avWait(avWait), .avRdata(avRdata),
    .avRead(avRead), .avWrite(avWrite), .avAddr(avAddr), .avWdata(avWdata),
    .busAck(busAck), .timerVal(timerVal)
  );

  a_r7_err_bus_quiet: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (!avRead && !avWrite));
endmodule

// File: tb/sim_pll_fb_recal.sv
module sim_pll_fb_recal;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int CAL_TO = 40;
  localparam int LOCK_TO = 30;
  localparam int PLLCAL = 'h100;
  localparam int CHBASE = 'h200;

  logic clk = 1'b0;
  logic rstN, start, pllSel, pllLocked, pllCalBusy;
  logic [NCH-1:0] pmaCalBusy;
  logic avRead, avWrite, avWait, done, error;
  logic [AW-1:0] avAddr;
  logic [DW-1:0] avWdata, avRdata;

  int checks = 0, fails = 0;
  bit finished = 0;

  // model knobs
  int stallLen = 0, calLen = 3, calGap = 2, lockDelay = 1;
  bit lockEn = 1, pllCalEn = 1;
  int chCalDisable = -1;
  // model state
  logic [31:0] regLc = 0, regFr = 0;
  int pendCnt = 0, pllCnt = 0, lockCnt = 0;
  bit lockArmed = 0;
  int chCnt[NCH];
  // access log
  int logN = 0;
  bit evWr[32];
  int evAddr[32];
  logic [31:0] evData[32];
  bit evLock[32];
  int holdViol = 0;
  bit prevPend = 0;
  logic [AW-1:0] prevAddr;
  logic [DW-1:0] prevData;
  logic prevRd, prevWr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_fb_recal #(.NCH(NCH), .AW(AW), .DW(DW), .CAL_TIMEOUT(CAL_TO),
                 .LOCK_TIMEOUT(LOCK_TO)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .pllSel(pllSel),
    .pllLocked(pllLocked), .pllCalBusy(pllCalBusy), .pmaCalBusy(pmaCalBusy),
    .avRead(avRead), .avWrite(avWrite), .avAddr(avAddr), .avWdata(avWdata),
    .avRdata(avRdata), .avWait(avWait), .done(done), .error(error));

  assign avWait = (avRead | avWrite) && (pendCnt < stallLen);
  assign avRdata = (avAddr == AW'('h110)) ? regLc :
                   (avAddr == AW'('h126)) ? regFr : 32'hDEAD_BEEF;
  assign pllCalBusy = pllCalEn && (pllCnt > 0) && (pllCnt <= calLen);
  assign pllLocked = lockEn && lockArmed && (lockCnt == 0);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign pmaCalBusy[k] = (chCalDisable != k) && (chCnt[k] > 0) && (chCnt[k] <= calLen);
  end

  always @(posedge clk) begin
    if ((avRead | avWrite) && avWait) pendCnt <= pendCnt + 1; else pendCnt <= 0;
    if (pllCnt > 0) pllCnt <= pllCnt - 1;
    if (pllCnt == 1) begin lockArmed <= 1; lockCnt <= lockDelay; end
    else if (lockCnt > 0) lockCnt <= lockCnt - 1;
    for (int k = 0; k < NCH; k++) if (chCnt[k] > 0) chCnt[k] <= chCnt[k] - 1;
    // R6 monitor: held request must not change
    if (prevPend && (avAddr !== prevAddr || avWdata !== prevData ||
                     avRead !== prevRd || avWrite !== prevWr || (avRead && avWrite)))
      holdViol <= holdViol + 1;
    prevPend <= (avRead | avWrite) && avWait;
    prevAddr <= avAddr; prevData <= avWdata; prevRd <= avRead; prevWr <= avWrite;
    if ((avRead | avWrite) && !avWait && logN < 32) begin
      evWr[logN] <= avWrite; evAddr[logN] <= int'(avAddr);
      evData[logN] <= avWdata; evLock[logN] <= pllLocked;
      logN <= logN + 1;
      if (avWrite) begin
        if (avAddr == AW'('h110)) regLc <= avWdata;
        if (avAddr == AW'('h126)) regFr <= avWdata;
        if (avAddr == AW'(PLLCAL)) begin pllCnt <= calGap + calLen; lockArmed <= 0; end
        for (int k = 0; k < NCH; k++)
          if (avAddr == AW'(CHBASE + k)) chCnt[k] <= calGap + calLen;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic kick(bit sel);
    @(negedge clk); start = 1; pllSel = sel;
    @(negedge clk); start = 0;
  endtask

  task automatic waitEnd(output bit gotDone, output bit gotErr);
    gotDone = 0; gotErr = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin gotDone = 1; break; end
      if (error) begin gotErr = 1; break; end
    end
  endtask

  task automatic runNormal(bit sel, int stall, logic [31:0] pat);
    bit gd, ge;
    int fbA;
    logic [31:0] m, init, other;
    stallLen = stall; calLen = 3 + stall; calGap = 2 + stall; lockDelay = 1 + 3*stall;
    lockEn = 1; pllCalEn = 1; chCalDisable = -1;
    @(negedge clk);
    regLc = pat; regFr = ~pat; logN = 0;
    fbA = sel ? 'h126 : 'h110;
    m = sel ? 32'h1 : 32'h4;
    init = sel ? ~pat : pat;
    other = sel ? pat : ~pat;
    kick(sel);
    waitEnd(gd, ge);
    chk(gd && !ge, "R9", "done reached without error", {gd, ge}, 2'b10);
    @(negedge clk);
    chk(!done, "R9", "done lasts one cycle", done, 0);
    chk(logN == 5 + NCH, "R5", "access count", logN, 5 + NCH);
    chk(!evWr[0] && evAddr[0] == fbA, "R1", "first read of feedback reg", evAddr[0], fbA);
    chk(evWr[1] && evAddr[1] == fbA && evData[1] == (init | m), "R2",
        "set write value", evData[1], init | m);
    chk(evWr[2] && evAddr[2] == PLLCAL && evData[2] == 1, "R3", "PLL cal request",
        evAddr[2], PLLCAL);
    chk(!evWr[3] && evAddr[3] == fbA, "R4", "second read of feedback reg", evAddr[3], fbA);
    chk(evWr[4] && evAddr[4] == fbA && evData[4] == (init & ~m), "R4",
        "restore write value", evData[4], init & ~m);
    chk(evLock[4] == 1, "R4", "restore only while locked", evLock[4], 1);
    for (int k = 0; k < NCH; k++)
      chk(evWr[5+k] && evAddr[5+k] == CHBASE + k && evData[5+k] == 1, "R5",
          "channel cal order", evAddr[5+k], CHBASE + k);
    chk((sel ? regLc : regFr) == other, "R1", "other register untouched",
        sel ? regLc : regFr, other);
    chk((sel ? regFr : regLc) == (init & ~m), "R2", "feedback reg final value",
        sel ? regFr : regLc, init & ~m);
  endtask

  initial begin
    bit gd, ge;
    int n;
    logic [31:0] pats[3];
    pats[0] = 32'h0; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h5A3C_96E1;
    for (int k = 0; k < NCH; k++) chCnt[k] = 0;
    rstN = 0; start = 0; pllSel = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!avRead, "R11", "read after reset", avRead, 0);
    chk(!avWrite, "R11", "write after reset", avWrite, 0);
    chk(!done, "R11", "done after reset", done, 0);
    chk(!error, "R11", "error after reset", error, 0);

    for (int sel = 0; sel < 2; sel++)
      for (int st = 0; st < 3; st++)
        for (int p = 0; p < 3; p++)
          runNormal(sel[0], st, pats[p]);

    // R10: start mid-run with the other select is ignored
    stallLen = 1; lockEn = 1; pllCalEn = 1; chCalDisable = -1;
    @(negedge clk); logN = 0; regLc = 32'h0F0F_0F0F; regFr = 32'h1234_5678;
    kick(0);
    repeat (4) @(negedge clk);
    kick(1);
    waitEnd(gd, ge);
    chk(gd, "R10", "run completes despite extra start", gd, 1);
    chk(logN == 5 + NCH, "R10", "single sequence of accesses", logN, 5 + NCH);
    n = 0;
    for (int i = 0; i < logN; i++) if (evAddr[i] == 'h126) n++;
    chk(n == 0 && evAddr[3] == 'h110, "R10", "select kept from first start", n, 0);
    chk(regFr == 32'h1234_5678, "R1", "fractional reg untouched", regFr, 32'h1234_5678);

    // R7: lock never arrives
    repeat (3) @(negedge clk);
    logN = 0; lockEn = 0;
    kick(0);
    waitEnd(gd, ge);
    chk(ge && !gd, "R7", "lock timeout raises error", {gd, ge}, 2'b01);
    chk(logN == 3, "R7", "no restore after lock timeout", logN, 3);
    repeat (20) @(negedge clk);
    chk(error && !done, "R7", "error held", {done, error}, 2'b01);
    chk(logN == 3, "R7", "bus quiet in error", logN, 3);

    // R8: PLL calibration never starts; restart from error
    lockEn = 1; pllCalEn = 0; logN = 0;
    kick(1);
    @(negedge clk);
    chk(!error, "R10", "start from error clears error", error, 0);
    waitEnd(gd, ge);
    chk(ge && !gd, "R8", "PLL cal timeout raises error", {gd, ge}, 2'b01);
    chk(logN == 3, "R8", "nothing after PLL cal timeout", logN, 3);

    // R8: middle channel never calibrates
    repeat (20) @(negedge clk);
    pllCalEn = 1; chCalDisable = 1; logN = 0;
    kick(0);
    waitEnd(gd, ge);
    chk(ge && !gd, "R8", "channel cal timeout raises error", {gd, ge}, 2'b01);
    chk(logN == 7 && evAddr[6] == CHBASE + 1, "R8", "stops at stuck channel", logN, 7);

    // recovery
    repeat (20) @(negedge clk);
    chCalDisable = -1; logN = 0;
    kick(0);
    waitEnd(gd, ge);
    chk(gd && !error, "R9", "recovery run completes", {gd, error}, 2'b10);
    chk(logN == 5 + NCH, "R5", "recovery access count", logN, 5 + NCH);

    chk(holdViol == 0, "R6", "request held while stalled", holdViol, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule